// File: doc/BRIEF.md
# SPI Slave Correlation-Code Receiver

This block is the hardware end of a byte-oriented SPI link from a microcontroller to the signal-processing side of a frequency-hopping radio. The master sends a start marker byte and then a fixed-length block of correlation code, one byte per exchange. The block deserializes each byte and keeps the payload in a register bank that stays visible as a flat parallel output. When the last payload byte arrives, it raises a single-cycle strobe.

The link is full duplex. During every byte the slave returns a correlation result on MISO. The result is taken from a parallel input when the byte starts, so the downstream correlator can present a new value at any time without corrupting a byte already in flight. The serial inputs are synchronized into the system clock domain, and edges are found on the synchronized clock. The system clock must therefore run well above the SPI bit rate.

Top module: `spi_cc_rx`

## Requirements
- R1: After reset, frame_valid_o is 0, miso_o is 0 and every bit of code_o is 0.
- R2: SCK idles low. MOSI is sampled on each falling SCK edge, least significant bit first, and a byte is complete after 8 falling edges while ss_ni is low.
- R3: While no frame is open, a received byte other than 0xAA produces no frame_valid_o pulse and leaves code_o unchanged.
- R4: A received 0xAA while no frame is open opens a frame. The next 10 bytes are stored in arrival order at indices 0 to 9, and index k appears on code_o[8k+7:8k].
- R5: After the tenth payload byte, frame_valid_o pulses high for exactly one clock cycle and the frame closes.
- R6: A 0xAA byte received inside an open frame is stored as payload data and does not restart the frame.
- R7: At the first rising SCK edge of each byte, corr_i is captured and MISO presents it least significant bit first, one bit per rising edge. MISO changes only after a rising SCK edge or a change of ss_ni, and a change of corr_i later in the byte has no effect on that byte.
- R8: While ss_ni is high, the bit counter is held at zero, a partially received byte is discarded and miso_o is 0.
- R9: Frame progress is kept while ss_ni is high, so a payload may be sent with ss_ni deasserted between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock from the master, idle low |
| mosi_i | input | 1 | Serial data from the master |
| ss_ni | input | 1 | Slave select, active low |
| corr_i | input | 8 | Correlation value to return to the master |
| miso_o | output | 1 | Serial data to the master |
| code_o | output | 80 | Payload bank, byte k at bits 8k+7:8k |
| frame_valid_o | output | 1 | One-cycle strobe after the last payload byte |

## Verification
The case that is hardest to reach is a byte cut short by slave-select deassertion inside an open frame. After the cut, the following full bytes must still land at the correct payload indices. The stimulus opens a frame, clocks three bits, raises ss_ni, and then sends the whole payload with ss_ni toggled between bytes. A frame that comes out shifted by one byte or misaligned by a few bits shows that the cut was handled wrongly. A second hard case is a change of corr_i after the byte has started. The bench flips corr_i after the third rising edge and expects the value captured before the flip to come back on MISO.

// File: rtl/spi_cc_pkg.sv
package spi_cc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {FR_IDLE, FR_LOAD} fr_state_e;
endpackage

// File: rtl/spi_cc_sync.sv
module spi_cc_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_cc_shift.sv
module spi_cc_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          mosi_s_i,
  input  logic          ss_s_i,
  input  logic [DW-1:0] corr_i,
  output logic          miso_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_vld_o,
  output logic          sck_rise_o
);
  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q;
  logic          rise, fall;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, tx_q, byte_q;
  logic          miso_q, vld_q;

  assign rise = sck_s_i & ~sck_q;
  assign fall = ~sck_s_i & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      byte_q <= '0;
      miso_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (ss_s_i) begin
      // deselected: drop partial byte
      cnt_q  <= '0;
      miso_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (fall) begin
        sh_q <= {mosi_s_i, sh_q[DW-1:1]};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          byte_q <= {mosi_s_i, sh_q[DW-1:1]};
          vld_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (rise) begin
        if (cnt_q == '0) begin
          tx_q   <= corr_i;
          miso_q <= corr_i[0];
        end else begin
          miso_q <= tx_q[cnt_q];
        end
      end
    end
  end

  assign miso_o     = miso_q;
  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign sck_rise_o = rise;
endmodule

// File: rtl/spi_cc_frame.sv
module spi_cc_frame
  import spi_cc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 10,
  parameter logic [DW-1:0] MARKER = 8'hAA
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  byte_i,
  input  logic           vld_i,
  output logic [NB*DW-1:0] code_o,
  output logic           frame_valid_o
);
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  fr_state_e            st_q;
  logic [IW-1:0]        idx_q;
  logic [NB-1:0][DW-1:0] bank_q;
  logic                 fv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      idx_q  <= '0;
      bank_q <= '0;
      fv_q   <= 1'b0;
    end else begin
      fv_q <= 1'b0;
      if (vld_i) begin
        case (st_q)
          FR_IDLE: if (byte_i == MARKER) begin
            st_q  <= FR_LOAD;
            idx_q <= '0;
          end
          FR_LOAD: begin
            bank_q[idx_q] <= byte_i;
            if (idx_q == LAST) begin
              st_q <= FR_IDLE;
              fv_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: st_q <= FR_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign code_o[g*DW +: DW] = bank_q[g];
  end

  assign frame_valid_o = fv_q;
endmodule

// File: rtl/spi_cc_rx.sv
module spi_cc_rx
  import spi_cc_pkg::*;
#(
  parameter int unsigned NB = 10,
  parameter logic [BYTE_W-1:0] MARKER = 8'hAA
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sck_i,
  input  logic                 mosi_i,
  input  logic                 ss_ni,
  input  logic [BYTE_W-1:0]    corr_i,
  output logic                 miso_o,
  output logic [NB*BYTE_W-1:0] code_o,
  output logic                 frame_valid_o
);
  logic [2:0]        sync_q;
  logic              sck_s, mosi_s, ss_s;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_vld, sck_rise;

  spi_cc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (sync_q)
  );
  assign sck_s  = sync_q[0];
  assign mosi_s = sync_q[1];
  assign ss_s   = sync_q[2];

  spi_cc_shift #(.DW(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .mosi_s_i  (mosi_s),
    .ss_s_i    (ss_s),
    .corr_i    (corr_i),
    .miso_o    (miso_o),
    .byte_o    (rx_byte),
    .byte_vld_o(byte_vld),
    .sck_rise_o(sck_rise)
  );

  spi_cc_frame #(.DW(BYTE_W), .NB(NB), .MARKER(MARKER)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_i       (rx_byte),
    .vld_i        (byte_vld),
    .code_o       (code_o),
    .frame_valid_o(frame_valid_o)
  );
endmodule

// File: rtl/spi_cc_rx_chk.sv
module spi_cc_rx_chk #(
  parameter int unsigned CODE_W = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_valid_o,
  input logic [CODE_W-1:0] code_o,
  input logic              miso_o,
  input logic              byte_vld,
  input logic              sck_rise,
  input logic              ss_s
);
  assert_fv_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  assert_fv_after_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $past(byte_vld));

  assert_code_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(code_o));

  assert_miso_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_rise && $stable(ss_s)) |=> $stable(miso_o));

  assert_miso_desel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_s && $past(ss_s)) |-> !miso_o);
endmodule

bind spi_cc_rx spi_cc_rx_chk #(.CODE_W(NB*8)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_valid_o(frame_valid_o),
  .code_o       (code_o),
  .miso_o       (miso_o),
  .byte_vld     (byte_vld),
  .sck_rise     (sck_rise),
  .ss_s         (ss_s)
);

// File: tb/sim_spi_cc_rx.sv
`timescale 1ns/1ps
module sim_spi_cc_rx;
  localparam int NB = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic [7:0] corr = 8'h00;
  logic miso, fv;
  logic [NB*8-1:0] code;

  int n_tests = 0, n_fail = 0;
  int fv_pulses = 0, fv_long = 0;
  logic fv_d = 1'b0;
  logic [7:0] exp_b [NB];
  logic [7:0] rxb;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cc_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .corr_i(corr), .miso_o(miso), .code_o(code), .frame_valid_o(fv)
  );

  always @(posedge clk) begin
    if (fv && !fv_d) fv_pulses <= fv_pulses + 1;
    if (fv && fv_d) fv_long <= fv_long + 1;
    fv_d <= fv;
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, input logic [7:0] cv,
                          input bit flip, output logic [7:0] rx);
    corr = cv;
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sck = 1'b1; mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      if (flip && i == 2) corr = ~cv;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, input logic [7:0] cv);
    logic [7:0] r;
    spi_bits(tx, 8, cv, 1'b0, r);
    rxb = r;
  endtask

  task automatic check_code(string req);
    for (int k = 0; k < NB; k++) check(req, int'(code[k*8 +: 8]), int'(exp_b[k]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int p0;
    repeat (4) @(negedge clk);
    check("R1 fv", int'(fv), 0);
    check("R1 miso", int'(miso), 0);
    check("R1 code", int'(code == '0), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);

    // R3 sweep of idle non-marker bytes, R7 return path per byte
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hAA) continue;
      spi_byte(8'(v), 8'(v) ^ 8'h5A);
      check("R7 miso byte", int'(rxb), int'(8'(v) ^ 8'h5A));
    end
    check("R3 no pulse", fv_pulses, 0);
    check("R3 code unchanged", int'(code == '0), 1);

    // R4/R2 frame
    spi_byte(8'hAA, 8'h00);
    for (int k = 0; k < NB; k++) begin
      exp_b[k] = 8'((k * 37 + 11) & 8'hFF);
      spi_byte(exp_b[k], 8'(k));
    end
    check_code("R4 R2 payload");
    check("R5 pulse count", fv_pulses, 1);
    check("R5 pulse width", fv_long, 0);

    // R5 frame closed: non-marker ignored
    spi_byte(8'h10, 8'h00);
    check_code("R5 closed");
    check("R5 no extra pulse", fv_pulses, 1);

    // R6 marker as data
    spi_byte(8'hAA, 8'h00);
    for (int k = 0; k < NB; k++) exp_b[k] = (k == 0 || k == 5) ? 8'hAA : 8'(8'hC3 ^ k);
    for (int k = 0; k < NB; k++) spi_byte(exp_b[k], 8'h00);
    check_code("R6 payload");
    check("R6 pulse count", fv_pulses, 2);

    // R7 corr change mid-byte ignored
    spi_bits(8'h01, 8, 8'h96, 1'b1, r);
    check("R7 mid-byte corr", int'(r), 8'h96);
    spi_byte(8'h02, 8'h3C);
    check("R7 next byte", int'(rxb), 8'h3C);

    // R8 partial byte discarded, R9 progress across deselect
    p0 = fv_pulses;
    spi_byte(8'hAA, 8'h00);
    spi_bits(8'hFF, 3, 8'hFF, 1'b0, r);
    ss_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 miso low", int'(miso), 0);
    for (int k = 0; k < NB; k++) begin
      exp_b[k] = 8'(k * 19 + 3);
      ss_n = 1'b0;
      repeat (4) @(negedge clk);
      spi_byte(exp_b[k], 8'h00);
      ss_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R8 miso low between", int'(miso), 0);
    end
    check_code("R8 R9 payload");
    check("R9 pulse", fv_pulses, p0 + 1);
    check("R5 width final", fv_long, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule